// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-rank SDRAM from the moment reset is released until the memory is ready for ordinary traffic. It first holds the bus in the no-operation state while a stabilization timer runs. It then issues a precharge of every bank, followed by a run of auto-refresh commands. It then loads the mode register with a word assembled from three configuration inputs: the read latency code, the burst ordering bit and the burst length code. A short settling wait follows, after which it raises `init_done` and leaves the bus in NOP for the controller that takes over.

All waits are parameters counted in clock cycles, so the block fits any clock rate once the integrator converts the nanosecond limits. The defaults suit a 100 MHz memory clock: a 20000-cycle pause, three cycles after precharge, ten cycles after each refresh and two cycles after the mode load. If the latency or length input carries a code that the memory reserves, the block flags the problem on `config_error`. It still completes the sequence, with a safe latency and length substituted.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst` is high, the pins show NOP (`mem_cs_n`,`mem_ras_n`,`mem_cas_n`,`mem_we_n` = 0,1,1,1), `mem_cke` is 1, `mem_addr` and `mem_ba` are 0, and `init_done` and `config_error` are 0.
- R2: `mem_cke` is 1 in every cycle.
- R3: After reset is released, only NOP is driven until the STABLE_CYC-th rising edge. That edge issues a precharge-all (0,0,1,0) with `mem_addr[10]` = 1 and `mem_ba` = 0.
- R4: NUM_REF auto-refresh commands (0,0,0,1) follow. The first comes PRE_WAIT cycles after the precharge, and each further one REF_WAIT cycles after the one before. Every command lasts one cycle, with NOP in between.
- R5: A mode load (0,0,0,0) comes REF_WAIT cycles after the last refresh. Its address carries the latency code in bits 6..4, the burst ordering bit in bit 3 (0 sequential, 1 interleaved) and the length code in bits 2..0. All other address bits and `mem_ba` are 0.
- R6: The valid latency codes 3'b010 (latency 2) and 3'b011 (latency 3), and the valid length codes 3'b001 (2), 3'b010 (4) and 3'b011 (8), reach the mode word unchanged.
- R7: If the latency code or the length code is any other value, `config_error` goes to 1 in the mode-load cycle. The mode word then uses latency code 3'b011 and length code 3'b010, and keeps the ordering bit.
- R8: `init_done` rises MRS_WAIT cycles after the mode load and stays 1 until reset. From then on the pins show NOP.
- R9: The configuration inputs are sampled only in the mode-load cycle. Changing them afterwards alters neither `config_error` nor the pins.
- R10: Asserting `rst` part-way through the sequence restarts it from the stabilization pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lat_code | input | 3 | Requested read-latency code |
| cfg_interleave | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| cfg_len_code | input | 3 | Requested burst-length code |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cke | output | 1 | Clock enable |
| mem_addr | output | ADDR_W | Address / mode word |
| mem_ba | output | BA_W | Bank address |
| init_done | output | 1 | Sequence finished |
| config_error | output | 1 | A reserved code was requested |

## Verification
The assertions assume that `rst` is held for at least one clock edge before the first check. They also assume that the configuration inputs carry defined values in the mode-load cycle, because the mode-word checks then require the latency and length fields to be legal codes. The stimulus drives `rst` high from time zero. It sets the configuration on a falling edge before each run and holds it until the run has finished, apart from the one scenario that changes it on purpose after `init_done` has risen.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS} cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam logic [2:0] LAT2 = 3'b010;
  localparam logic [2:0] LAT3 = 3'b011;
  localparam logic [2:0] LEN2 = 3'b001;
  localparam logic [2:0] LEN4 = 3'b010;
  localparam logic [2:0] LEN8 = 3'b011;

  function automatic pins_t pins_of(cmd_e c);
    case (c)
      CMD_PRE: return '{1'b0, 1'b0, 1'b1, 1'b0};
      CMD_REF: return '{1'b0, 1'b0, 1'b0, 1'b1};
      CMD_MRS: return '{1'b0, 1'b0, 1'b0, 1'b0};
      default: return '{1'b0, 1'b1, 1'b1, 1'b1};
    endcase
  endfunction

endpackage

// File: rtl/sdram_mode_word.sv
module sdram_mode_word
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        lat_code,
  input  logic              interleave,
  input  logic [2:0]        len_code,
  output logic [ADDR_W-1:0] word,
  output logic              bad
);
  logic lat_ok, len_ok;

  always_comb begin
    lat_ok = (lat_code == LAT2) || (lat_code == LAT3);
    len_ok = (len_code == LEN2) || (len_code == LEN4) || (len_code == LEN8);
    bad    = !(lat_ok && len_ok);
    word   = '0;
    word[6:4] = bad ? LAT3 : lat_code;
    word[3]   = interleave;
    word[2:0] = bad ? LEN4 : len_code;
  end
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int STABLE_CYC = 20000,
  parameter int PRE_WAIT   = 3,
  parameter int REF_WAIT   = 10,
  parameter int MRS_WAIT   = 2,
  parameter int NUM_REF    = 8
) (
  input  logic clk,
  input  logic rst,
  output cmd_e issue,
  output logic done_set
);
  localparam int REFS  = (NUM_REF < 1) ? 1 : NUM_REF;
  localparam int M1    = (PRE_WAIT > REF_WAIT) ? PRE_WAIT : REF_WAIT;
  localparam int M2    = (M1 > MRS_WAIT) ? M1 : MRS_WAIT;
  localparam int MAXW  = (M2 > STABLE_CYC) ? M2 : STABLE_CYC;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam int REF_W = $clog2(REFS + 1);

  localparam logic [CNT_W-1:0] LIM_STAB = CNT_W'(STABLE_CYC - 1);
  localparam logic [CNT_W-1:0] LIM_PRE  = CNT_W'(PRE_WAIT - 1);
  localparam logic [CNT_W-1:0] LIM_REF  = CNT_W'(REF_WAIT - 1);
  localparam logic [CNT_W-1:0] LIM_MRS  = CNT_W'(MRS_WAIT - 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REFS);

  typedef enum logic [2:0] {ST_STAB, ST_PRE, ST_REF, ST_MRS, ST_DONE} st_e;

  st_e              state, nxt;
  logic [CNT_W-1:0] cnt, limit;
  logic [REF_W-1:0] ref_cnt;
  logic             hit;

  always_comb begin
    case (state)
      ST_STAB: limit = LIM_STAB;
      ST_PRE:  limit = LIM_PRE;
      ST_REF:  limit = LIM_REF;
      default: limit = LIM_MRS;
    endcase
    hit      = (cnt == limit);
    issue    = CMD_NOP;
    done_set = 1'b0;
    nxt      = state;
    case (state)
      ST_STAB: if (hit) begin issue = CMD_PRE; nxt = ST_PRE; end
      ST_PRE:  if (hit) begin issue = CMD_REF; nxt = ST_REF; end
      ST_REF:  if (hit) begin
                 if (ref_cnt == REF_LAST) begin issue = CMD_MRS; nxt = ST_MRS; end
                 else issue = CMD_REF;
               end
      ST_MRS:  if (hit) begin done_set = 1'b1; nxt = ST_DONE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_STAB;
      cnt     <= '0;
      ref_cnt <= '0;
    end else begin
      state <= nxt;
      if (issue != CMD_NOP || done_set) cnt <= '0;
      else if (state != ST_DONE)        cnt <= cnt + 1'b1;
      if (issue == CMD_REF) ref_cnt <= ref_cnt + 1'b1;
    end
  end

  AST_REF_BOUND: assert property (@(posedge clk) disable iff (rst)
    ref_cnt <= REF_LAST);  // R4
  AST_MRS_AFTER_ALL_REF: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MRS) |-> (ref_cnt == REF_LAST));  // R4
  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (state != ST_DONE) |-> (cnt <= limit));  // R3
endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int AP_BIT     = 10,
  parameter int STABLE_CYC = 20000,
  parameter int PRE_WAIT   = 3,
  parameter int REF_WAIT   = 10,
  parameter int MRS_WAIT   = 2,
  parameter int NUM_REF    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_lat_code,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_len_code,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_cke,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BA_W-1:0]   mem_ba,
  output logic              init_done,
  output logic              config_error
);
  localparam logic [ADDR_W-1:0] AP_WORD = ADDR_W'(1) << AP_BIT;

  cmd_e              issue;
  logic              done_set;
  logic [ADDR_W-1:0] mode_word;
  logic              mode_bad;
  pins_t             pins_q;

  sdram_init_fsm #(
    .STABLE_CYC(STABLE_CYC), .PRE_WAIT(PRE_WAIT), .REF_WAIT(REF_WAIT),
    .MRS_WAIT(MRS_WAIT), .NUM_REF(NUM_REF)
  ) u_fsm (
    .clk(clk), .rst(rst), .issue(issue), .done_set(done_set)
  );

  sdram_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .lat_code(cfg_lat_code), .interleave(cfg_interleave),
    .len_code(cfg_len_code), .word(mode_word), .bad(mode_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q       <= pins_of(CMD_NOP);
      mem_addr     <= '0;
      mem_ba       <= '0;
      mem_cke      <= 1'b1;
      init_done    <= 1'b0;
      config_error <= 1'b0;
    end else begin
      pins_q  <= pins_of(issue);
      mem_ba  <= '0;
      mem_cke <= 1'b1;
      case (issue)
        CMD_PRE: mem_addr <= AP_WORD;
        CMD_MRS: mem_addr <= mode_word;
        default: mem_addr <= '0;
      endcase
      if (issue == CMD_MRS) config_error <= mode_bad;
      if (done_set)         init_done    <= 1'b1;
    end
  end

  assign mem_cs_n  = pins_q.cs_n;
  assign mem_ras_n = pins_q.ras_n;
  assign mem_cas_n = pins_q.cas_n;
  assign mem_we_n  = pins_q.we_n;

  logic on_pre, on_mrs, on_nop;
  assign on_pre = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0010;
  assign on_mrs = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0000;
  assign on_nop = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0111;

  AST_CKE_HIGH: assert property (@(posedge clk) disable iff (rst)
    mem_cke);  // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    on_pre |-> mem_addr[AP_BIT]);  // R3
  AST_MRS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    on_mrs |-> (mem_addr[ADDR_W-1:7] == '0) && (mem_ba == '0));  // R5
  AST_MRS_LEGAL_CODES: assert property (@(posedge clk) disable iff (rst)
    on_mrs |-> ((mem_addr[6:4] == LAT2) || (mem_addr[6:4] == LAT3)) &&
               ((mem_addr[2:0] == LEN2) || (mem_addr[2:0] == LEN4) ||
                (mem_addr[2:0] == LEN8)));  // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);  // R8
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    init_done |-> on_nop);  // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (init_done && config_error) |=> config_error);  // R9
endmodule

// File: tb/sim_sdram_powerup_seq.sv
module sim_sdram_powerup_seq;
  localparam int S = 40, P = 3, R = 10, N = 8, M = 2;
  localparam int TM = S + P + N * R;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] lat = 3'b011, len = 3'b010;
  logic bt = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, done, err;
  logic [11:0] addr;
  logic [1:0] ba;
  int n_chk = 0, n_err = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_powerup_seq #(
    .STABLE_CYC(S), .PRE_WAIT(P), .REF_WAIT(R), .MRS_WAIT(M), .NUM_REF(N)
  ) u0 (
    .clk(clk), .rst(rst), .cfg_lat_code(lat), .cfg_interleave(bt),
    .cfg_len_code(len), .mem_cs_n(cs_n), .mem_ras_n(ras_n),
    .mem_cas_n(cas_n), .mem_we_n(we_n), .mem_cke(cke), .mem_addr(addr),
    .mem_ba(ba), .init_done(done), .config_error(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input int k);
    if (k == S) return 4'b0010;
    for (int i = 0; i < N; i++) if (k == S + P + i * R) return 4'b0001;
    if (k == TM) return 4'b0000;
    return 4'b0111;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 reset pins", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    check(cke && addr == 0 && ba == 0, "R1 reset cke/addr/ba", {cke, addr, ba}, 15'h4000);
    check(!done && !err, "R1 reset flags", {done, err}, 0);
    rst = 1'b0;
  endtask

  task automatic run_sequence(input logic [2:0] l, input logic b, input logic [2:0] n,
                              input bit exp_err, input string tag);
    logic [11:0] word;
    int sched_bad = 0, cke_bad = 0;
    word = exp_err ? {5'b0, 3'b011, b, 3'b010} : {5'b0, l, b, n};
    @(negedge clk);
    lat = l; bt = b; len = n;
    do_reset();
    for (int k = 1; k <= TM + M + 2; k++) begin
      logic [3:0] c;
      @(negedge clk);
      c = {cs_n, ras_n, cas_n, we_n};
      if (c != exp_cmd(k)) begin
        sched_bad++;
        $display("  mismatch at cycle %0d: %b vs %b", k, c, exp_cmd(k));
      end
      if (!cke) cke_bad++;
      if (k == S) begin
        check(c == 4'b0010, {tag, " R3 precharge"}, c, 4'b0010);
        check(addr[10] && ba == 0, {tag, " R3 all-bank bit"}, {addr[10], ba}, 4);
      end
      for (int i = 0; i < N; i++)
        if (k == S + P + i * R) check(c == 4'b0001, {tag, " R4 refresh"}, c, 4'b0001);
      if (k == TM) begin
        check(c == 4'b0000, {tag, " R5 mode load"}, c, 0);
        check(addr == word && ba == 0, {tag, " R5 R6 R7 mode word"}, {ba, addr}, word);
        check(err == exp_err, {tag, " R7 config_error"}, err, exp_err);
      end
      if (k == TM + M - 1) check(!done, {tag, " R8 done early"}, done, 0);
      if (k == TM + M)     check(done,  {tag, " R8 done"}, done, 1);
    end
    check(sched_bad == 0, {tag, " R4 command schedule"}, sched_bad, 0);
    check(cke_bad == 0, {tag, " R2 cke"}, cke_bad, 0);
  endtask

  task automatic t_after_done();
    run_sequence(3'b011, 1'b0, 3'b011, 1'b0, "pre-R9");
    @(negedge clk);
    lat = 3'b111; len = 3'b000;
    repeat (6) @(negedge clk);
    check(!err, "R9 error ignores late config", err, 0);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == 0, "R9 pins stay NOP",
          {cs_n, ras_n, cas_n, we_n, addr}, 16'h7000);
    check(done, "R9 R8 done held", done, 1);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    lat = 3'b010; len = 3'b001; bt = 1'b1;
    do_reset();
    repeat (S + P + 2 * R) @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0001, "R10 mid-run refresh seen",
          {cs_n, ras_n, cas_n, we_n}, 1);
    run_sequence(3'b010, 1'b1, 3'b001, 1'b0, "R10 restart");
  endtask

  initial begin
    run_sequence(3'b010, 1'b0, 3'b001, 1'b0, "R6 lat2 seq len2");
    run_sequence(3'b011, 1'b1, 3'b011, 1'b0, "R6 lat3 intl len8");
    run_sequence(3'b000, 1'b1, 3'b010, 1'b1, "R7 reserved lat");
    run_sequence(3'b010, 1'b0, 3'b111, 1'b1, "R7 reserved len");
    t_after_done();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected<100000", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule